// File: doc/BRIEF.md
# Per-Set Round-Robin Victim Way Selector

This block picks which way of a 32-way set-associative cache receives the next line fill. Every set holds its own replacement pointer. The cache presents the set index of a pending fill together with that set's lock count. The block answers in the same cycle with the way to overwrite. When the write strobe is high, the pointer of that one set steps past the way just written. The pointers of all other sets stay where they are.

Locked lines always occupy the lowest-numbered ways of a set. When a pointer runs past the top way, it does not wrap to way 0. It resumes at the first way above the locked region. After reset every pointer names the top way. If a set's lock count is raised past its pointer, the next victim is the first unlocked way, so a locked line is never chosen. The number of sets is a parameter.

Top module: `rr_way_select`

## Requirements
- R1: After reset, the victim presented for every set is way 31.
- R2: `victim_way` is a combinational function of `fill_set`, that set's lock count and that set's pointer, so it is valid in the same cycle the set is presented.
- R3: A fill (`fill_we` = 1) into way N, where N < 31, makes way N+1 the next victim of that set, provided the lock count is unchanged.
- R4: A fill into one set leaves the victim of every other set unchanged.
- R5: A fill into way 31 makes the next victim of that set equal to its lock count, which is way 0 when the count is 0 and way 31 when the count is 31.
- R6: A cycle with `fill_we` = 0 changes no pointer.
- R7: The victim way is never below the lock count of the presented set.
- R8: If the lock count of a set exceeds its pointer, the victim is the lock count itself, and a fill there moves the pointer to lock count + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_set | input | SET_W | Set index of the lookup or fill |
| fill_we | input | 1 | High when a line is written into `victim_way` of `fill_set` this cycle |
| lock_cnt | input | NUM_SETS*5 | Packed lock counts (0..31). Set s occupies bits [s*5 +: 5] |
| victim_way | output | 5 | Way to replace in `fill_set` |

## Verification
On every cycle, the assertions check the lock floor (R7), the post-reset value (R1) and the step, wrap and hold behaviour of a set that is presented on two consecutive cycles with an unchanged lock count (R3, R5, R6). The isolation between sets (R4) only shows up when the bench leaves one set, fills others and later returns to it. The same holds for the raised-lock-count jump (R8), the full 32-fill walk of a set, and a reset that arrives mid-run.

// File: rtl/rr_way_select.sv
module rr_way_select #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 32,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SET_W-1:0]          fill_set,
  input  logic                      fill_we,
  input  logic [NUM_SETS*WAY_W-1:0] lock_cnt,
  output logic [WAY_W-1:0]          victim_way
);

  localparam logic [WAY_W-1:0] TOP_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] ptr  [NUM_SETS];
  logic [WAY_W-1:0] pick [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [WAY_W-1:0] lk;
    logic             sel;
    assign lk      = lock_cnt[s*WAY_W +: WAY_W];
    assign pick[s] = (ptr[s] < lk) ? lk : ptr[s];
    assign sel     = fill_we && (fill_set == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr[s] <= TOP_WAY;
      else if (sel)
        ptr[s] <= (pick[s] == TOP_WAY) ? lk : pick[s] + 1'b1;
    end
  end

  assign victim_way = pick[fill_set];

endmodule

module rr_way_select_chk #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 32,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SET_W-1:0]          fill_set,
  input logic                      fill_we,
  input logic [NUM_SETS*WAY_W-1:0] lock_cnt,
  input logic [WAY_W-1:0]          victim_way
);
  logic [WAY_W-1:0] lk;
  assign lk = lock_cnt[fill_set*WAY_W +: WAY_W];

  assert_lock_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    victim_way >= lk);

  assert_reset_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> victim_way == WAY_W'(WAYS - 1));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_we) && $stable(fill_set) && $stable(lk)
     && $past(victim_way) != WAY_W'(WAYS - 1))
    |-> victim_way == $past(victim_way) + 1'b1);

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_we) && $stable(fill_set) && $stable(lk)
     && $past(victim_way) == WAY_W'(WAYS - 1))
    |-> victim_way == lk);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fill_we) && $stable(fill_set) && $stable(lk))
    |-> $stable(victim_way));
endmodule

bind rr_way_select rr_way_select_chk #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_set(fill_set), .fill_we(fill_we),
  .lock_cnt(lock_cnt), .victim_way(victim_way)
);

// File: tb/tb_rr_way_select.sv
module tb_rr_way_select;
  localparam int NUM_SETS = 16;
  localparam int WAY_W = 5;
  localparam int SET_W = 4;

  logic clk = 0, rst_n = 0, fill_we = 0;
  logic [SET_W-1:0] fill_set = '0;
  logic [NUM_SETS*WAY_W-1:0] lock_cnt = '0;
  logic [WAY_W-1:0] victim_way;
  int runs = 0, fails = 0;
  bit done = 0;

  rr_way_select #(.NUM_SETS(NUM_SETS)) dut (
    .clk(clk), .rst_n(rst_n), .fill_set(fill_set), .fill_we(fill_we),
    .lock_cnt(lock_cnt), .victim_way(victim_way));

  always #5 clk = ~clk;

  // {set, we, lock of that set, expected victim before the edge, requirement}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {4'd0, 1'b0, 5'd0, 5'd31, 4'd1},
    {4'd0, 1'b1, 5'd0, 5'd31, 4'd5},
    {4'd0, 1'b1, 5'd0, 5'd0,  4'd3},
    {4'd0, 1'b1, 5'd0, 5'd1,  4'd3},
    {4'd1, 1'b0, 5'd0, 5'd31, 4'd4},
    {4'd0, 1'b0, 5'd0, 5'd2,  4'd6},
    {4'd2, 1'b1, 5'd3, 5'd31, 4'd5},
    {4'd2, 1'b1, 5'd3, 5'd3,  4'd5},
    {4'd2, 1'b0, 5'd6, 5'd6,  4'd8},
    {4'd2, 1'b1, 5'd6, 5'd6,  4'd8},
    {4'd2, 1'b0, 5'd6, 5'd7,  4'd8},
    {4'd0, 1'b0, 5'd0, 5'd2,  4'd4}
  };

  task automatic check(input logic [WAY_W-1:0] exp, input string req);
    runs++;
    if (victim_way !== exp) begin
      fails++;
      $display("FAIL %s: victim_way=%0d expected=%0d", req, victim_way, exp);
    end
  endtask

  task automatic step(input int s, input bit we, input int lk,
                      input logic [WAY_W-1:0] exp, input string req);
    @(negedge clk);
    fill_set = SET_W'(s);
    fill_we = we;
    lock_cnt[s*WAY_W +: WAY_W] = WAY_W'(lk);
    #1 check(exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // vector walk (R1, R2, R3, R4, R5, R6, R8)
    for (int i = 0; i < NV; i++)
      step(int'(VEC[i][18:15]), VEC[i][14], int'(VEC[i][13:9]), VEC[i][8:4],
           $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    // R5: full walk of set 1 with no locks; R2 same-cycle answer
    for (int n = 0; n < 33; n++)
      step(1, 1, 0, (n == 0) ? 5'd31 : WAY_W'(n - 1), "R5 walk");
    step(1, 0, 0, 5'd0, "R5 wrap after walk");
    // R5/R7: everything but the top way locked
    step(3, 1, 31, 5'd31, "R7 lock31");
    step(3, 0, 31, 5'd31, "R5 lock31 wrap");
    // R7: lock count above pointer in set 0 (pointer at 2)
    step(0, 0, 20, 5'd20, "R7 floor");
    step(0, 0, 0, 5'd2, "R7 floor released");
    // R1: reset in mid-run
    @(negedge clk); rst_n = 0; fill_we = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    step(0, 0, 0, 5'd31, "R1 set0");
    step(2, 0, 6, 5'd31, "R1 set2");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); runs++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule